// File: doc/BRIEF.md
# Power-On Strap Capture and Frequency Code Selector

This block samples a set of dual-use board pins while the chip is held in power-on reset, stores their levels once, and then hands the same pins over to the clock output drivers. The stored levels give the hardware frequency code and stay readable for software. They are never sampled again until the next power-on reset.

A configuration byte decides where the effective 4-bit frequency code comes from. When its source bit is clear, the code comes from the captured straps. When the bit is set, the code comes from four register bits that are not next to each other. The same byte also carries the spread-modulation enable and the spread shape. All results leave the block from registers, so a configuration change shows at the outputs only after a clock edge.

Top module: `strap_fsel_top`

## Requirements
- R1: While `por_n` is low, every bit of `pin_oe_o` is 0, so the strap resistors alone set the pin level.
- R2: Take the clock edges that follow the rise of `por_n`. `pin_oe_o` stays 0 after the first and second edges. It becomes all ones after the third edge and stays there until the next reset.
- R3: After the capture, `strap_rb_o` equals the levels that were held on `strap_pin_i` during reset. Bit i of the readback is bit i of the pins.
- R4: Once `pin_oe_o` is set, changes on `strap_pin_i` have no effect on `strap_rb_o`, or on `freq_code_o` while straps are selected.
- R5: When `cfg_byte_i[3]` is 0, `freq_code_o[i]` equals captured strap bit i, for i = 0 to 3.
- R6: When `cfg_byte_i[3]` is 1, `freq_code_o` is {`cfg_byte_i[2]`, `cfg_byte_i[6]`, `cfg_byte_i[5]`, `cfg_byte_i[4]`}, most significant bit first.
- R7: `ss_en_o` follows `cfg_byte_i[1]`. A value of 1 turns on spread modulation.
- R8: `ss_down_o` follows `cfg_byte_i[7]`. A value of 1 selects downward spread and 0 selects centred spread.
- R9: `freq_code_o`, `ss_en_o` and `ss_down_o` take a new configuration value on the first rising clock edge after it is driven. They do not change before that edge.
- R10: While `por_n` is low, `strap_rb_o`, `freq_code_o`, `ss_en_o` and `ss_down_o` are all 0, whatever the configuration byte holds.
- R11: Each new power-on reset pulse captures the strap levels again, replacing the previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| strap_pin_i | input | STRAP_W (5) | Level seen on the dual-use pins |
| cfg_byte_i | input | 8 | Configuration byte: bit 3 selects the source, bits 2,6,5,4 hold the register code, bit 1 enables spread, bit 7 selects the spread shape |
| freq_code_o | output | CODE_W (4) | Effective frequency code |
| ss_en_o | output | 1 | Spread modulation enable |
| ss_down_o | output | 1 | 1 = downward spread, 0 = centred spread |
| pin_oe_o | output | STRAP_W (5) | Output enables for the dual-use pins |
| strap_rb_o | output | STRAP_W (5) | Captured strap levels, for readback |

## Verification
A capture taken at the wrong edge, or a latch that keeps following the pins, shows up on `strap_rb_o` one clock after the pins move under enabled drivers. The enables rise at one exact edge, so a miscounted release path moves `pin_oe_o` by a whole cycle and can be seen at once. A bad bit mapping in the register code, or a swapped source select, gives a wrong `freq_code_o` on the first edge after the configuration is driven. A path that bypasses the output registers shows as a change before that edge.

// File: rtl/strap_fsel_pkg.sv
package strap_fsel_pkg;

    localparam int CFG_W      = 8;
    localparam int SRC_BIT    = 3;
    localparam int SSEN_BIT   = 1;
    localparam int SSDN_BIT   = 7;
    localparam int REG_CODE_W = 4;

    // register bit feeding code bit i (index 0 = least significant)
    localparam int REG_CODE_POS [REG_CODE_W] = '{4, 5, 6, 2};

    typedef enum logic {
        PH_HOLD = 1'b0,
        PH_RUN  = 1'b1
    } cap_phase_e;

    typedef struct packed {
        logic [REG_CODE_W-1:0] code;
        logic                  ss_en;
        logic                  ss_down;
    } fsel_state_t;

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    // no reset: these flops must keep sampling the pins during reset
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        stage_q[0] <= d_i;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            stage_q[g] <= stage_q[g-1];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/por_release.sv
module por_release #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    output logic rel_o
);
    logic [STAGES-1:0] rel_d, rel_q;

    always_comb begin
        rel_d = {rel_q[STAGES-2:0], 1'b1};
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) rel_q <= '0;
        else        rel_q <= rel_d;
    end

    assign rel_o = rel_q[STAGES-1];
endmodule

// File: rtl/strap_capture.sv
module strap_capture
    import strap_fsel_pkg::*;
#(
    parameter int STRAP_W = 5
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               rel_i,
    input  logic [STRAP_W-1:0] strap_s_i,
    output logic [STRAP_W-1:0] latch_o,
    output logic [STRAP_W-1:0] latch_next_o,
    output logic [STRAP_W-1:0] oe_o
);
    typedef struct packed {
        cap_phase_e         phase;
        logic [STRAP_W-1:0] latch;
    } cap_state_t;

    cap_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.phase == PH_HOLD && rel_i) begin
            st_d.latch = strap_s_i;
            st_d.phase = PH_RUN;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '{phase: PH_HOLD, latch: '0};
        else        st_q <= st_d;
    end

    assign latch_o      = st_q.latch;
    assign latch_next_o = st_d.latch;

    for (genvar g = 0; g < STRAP_W; g++) begin : g_oe
        assign oe_o[g] = (st_q.phase == PH_RUN);
    end
endmodule

// File: rtl/fsel_mux.sv
module fsel_mux
    import strap_fsel_pkg::*;
#(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic [CFG_W-1:0]  cfg_byte_i,
    input  logic [CODE_W-1:0] strap_code_i,
    output logic [CODE_W-1:0] code_o,
    output logic              ss_en_o,
    output logic              ss_down_o
);
    fsel_state_t st_d, st_q;
    logic [CODE_W-1:0] reg_code;

    for (genvar g = 0; g < CODE_W; g++) begin : g_gather
        assign reg_code[g] = cfg_byte_i[REG_CODE_POS[g]];
    end

    always_comb begin
        st_d         = st_q;
        st_d.code    = cfg_byte_i[SRC_BIT] ? reg_code : strap_code_i;
        st_d.ss_en   = cfg_byte_i[SSEN_BIT];
        st_d.ss_down = cfg_byte_i[SSDN_BIT];
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign code_o    = st_q.code;
    assign ss_en_o   = st_q.ss_en;
    assign ss_down_o = st_q.ss_down;
endmodule

// File: rtl/strap_fsel_top.sv
module strap_fsel_top
    import strap_fsel_pkg::*;
#(
    parameter int STRAP_W     = 5,
    parameter int CODE_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic [STRAP_W-1:0] strap_pin_i,
    input  logic [7:0]         cfg_byte_i,
    output logic [CODE_W-1:0]  freq_code_o,
    output logic               ss_en_o,
    output logic               ss_down_o,
    output logic [STRAP_W-1:0] pin_oe_o,
    output logic [STRAP_W-1:0] strap_rb_o
);
    logic               rel;
    logic [STRAP_W-1:0] strap_s;
    logic [STRAP_W-1:0] latch_next;

    strap_sync #(.W(STRAP_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .d_i (strap_pin_i),
        .q_o (strap_s)
    );

    por_release #(.STAGES(SYNC_STAGES)) u_rel (
        .clk   (clk),
        .por_n (por_n),
        .rel_o (rel)
    );

    strap_capture #(.STRAP_W(STRAP_W)) u_cap (
        .clk          (clk),
        .por_n        (por_n),
        .rel_i        (rel),
        .strap_s_i    (strap_s),
        .latch_o      (strap_rb_o),
        .latch_next_o (latch_next),
        .oe_o         (pin_oe_o)
    );

    fsel_mux #(.CODE_W(CODE_W)) u_mux (
        .clk          (clk),
        .por_n        (por_n),
        .cfg_byte_i   (cfg_byte_i),
        .strap_code_i (latch_next[CODE_W-1:0]),
        .code_o       (freq_code_o),
        .ss_en_o      (ss_en_o),
        .ss_down_o    (ss_down_o)
    );
endmodule

// File: rtl/strap_fsel_chk.sv
module strap_fsel_chk #(
    parameter int STRAP_W = 5,
    parameter int CODE_W  = 4
) (
    input logic               clk,
    input logic               por_n,
    input logic [STRAP_W-1:0] strap_pin_i,
    input logic [7:0]         cfg_byte_i,
    input logic [CODE_W-1:0]  freq_code_o,
    input logic               ss_en_o,
    input logic               ss_down_o,
    input logic [STRAP_W-1:0] pin_oe_o,
    input logic [STRAP_W-1:0] strap_rb_o
);
    assert_oe_off_in_reset_R1: assert property (@(posedge clk)
        !por_n |-> pin_oe_o == '0);

    assert_oe_uniform_R2: assert property (@(posedge clk) disable iff (!por_n)
        (pin_oe_o == '0) || (&pin_oe_o));

    assert_oe_sticky_R2: assert property (@(posedge clk) disable iff (!por_n)
        $past(&pin_oe_o) |-> &pin_oe_o);

    assert_latch_frozen_R4: assert property (@(posedge clk) disable iff (!por_n)
        (&pin_oe_o) && $past(&pin_oe_o) |-> $stable(strap_rb_o));

    assert_strap_source_R5: assert property (@(posedge clk) disable iff (!por_n)
        $past(por_n) && $past(&pin_oe_o) && !$past(cfg_byte_i[3])
        |-> freq_code_o == $past(strap_rb_o[CODE_W-1:0]));

    assert_reg_source_R6: assert property (@(posedge clk) disable iff (!por_n)
        $past(por_n) && $past(cfg_byte_i[3])
        |-> freq_code_o == $past({cfg_byte_i[2], cfg_byte_i[6], cfg_byte_i[5], cfg_byte_i[4]}));

    assert_spread_en_R7: assert property (@(posedge clk) disable iff (!por_n)
        $past(por_n) |-> ss_en_o == $past(cfg_byte_i[1]));

    assert_spread_shape_R8: assert property (@(posedge clk) disable iff (!por_n)
        $past(por_n) |-> ss_down_o == $past(cfg_byte_i[7]));

    assert_quiet_in_reset_R10: assert property (@(posedge clk)
        !por_n |-> (strap_rb_o == '0) && (freq_code_o == '0) && !ss_en_o && !ss_down_o);
endmodule

bind strap_fsel_top strap_fsel_chk #(.STRAP_W(STRAP_W), .CODE_W(CODE_W)) u_chk (
    .clk         (clk),
    .por_n       (por_n),
    .strap_pin_i (strap_pin_i),
    .cfg_byte_i  (cfg_byte_i),
    .freq_code_o (freq_code_o),
    .ss_en_o     (ss_en_o),
    .ss_down_o   (ss_down_o),
    .pin_oe_o    (pin_oe_o),
    .strap_rb_o  (strap_rb_o)
);

// File: tb/strap_fsel_top_bench.sv
module strap_fsel_top_bench;
    localparam int SW = 5;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          por_n = 1'b1;
    logic [SW-1:0] strap_pin = '0;
    logic [7:0]    cfg = '0;
    logic [CW-1:0] freq_code;
    logic          ss_en, ss_down;
    logic [SW-1:0] pin_oe, strap_rb;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    strap_fsel_top u_strap_fsel_top (
        .clk         (clk),
        .por_n       (por_n),
        .strap_pin_i (strap_pin),
        .cfg_byte_i  (cfg),
        .freq_code_o (freq_code),
        .ss_en_o     (ss_en),
        .ss_down_o   (ss_down),
        .pin_oe_o    (pin_oe),
        .strap_rb_o  (strap_rb)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [CW-1:0] exp_code(input logic [7:0] b, input logic [SW-1:0] s);
        return b[3] ? {b[2], b[6], b[5], b[4]} : s[CW-1:0];
    endfunction

    task automatic power_cycle(input logic [SW-1:0] s, input logic [7:0] cfg_rst,
                               input logic [7:0] cfg_run);
        @(negedge clk);
        por_n     = 1'b0;
        strap_pin = s;
        cfg       = cfg_rst;
        repeat (4) @(negedge clk);
        chk("R1 oe in reset", 32'(pin_oe), 32'h0);
        chk("R10 readback in reset", 32'(strap_rb), 32'h0);
        chk("R10 outputs in reset", {26'h0, freq_code, ss_en, ss_down}, 32'h0);
        por_n = 1'b1;
        cfg   = cfg_run;
        @(negedge clk);
        chk("R2 oe after edge 1", 32'(pin_oe), 32'h0);
        @(negedge clk);
        chk("R2 oe after edge 2", 32'(pin_oe), 32'h0);
        @(negedge clk);
        chk("R2 oe after edge 3", 32'(pin_oe), 32'h1F);
        chk("R3 R11 captured straps", 32'(strap_rb), 32'(s));
        chk("R5 strap code", 32'(freq_code), 32'(exp_code(cfg_run, s)));
    endtask

    initial begin
        #1 por_n = 1'b0;
        for (int s = 0; s < 32; s++) begin
            power_cycle(SW'(s), (s % 2 == 1) ? 8'hFF : 8'h8A, 8'h00);
        end
        for (int k = 0; k < 4; k++) begin
            logic [SW-1:0] s;
            logic [7:0]    prev;
            s = (k == 0) ? 5'h00 : (k == 1) ? 5'h1F : (k == 2) ? 5'h0A : 5'h15;
            power_cycle(s, 8'h00, 8'h00);
            prev = 8'h00;
            for (int b = 0; b < 256; b++) begin
                @(negedge clk);
                cfg       = 8'(b);
                strap_pin = ~s ^ 5'(b);
                #1;
                chk("R9 no early change", {ss_down, ss_en, 26'h0, freq_code},
                    {prev[7], prev[1], 26'h0, exp_code(prev, s)});
                @(negedge clk);
                chk(cfg[3] ? "R6 register code" : "R5 strap code",
                    32'(freq_code), 32'(exp_code(8'(b), s)));
                chk("R7 spread enable", 32'(ss_en), 32'(b[1]));
                chk("R8 spread shape", 32'(ss_down), 32'(b[7]));
                chk("R4 readback frozen", 32'(strap_rb), 32'(s));
                chk("R2 oe held", 32'(pin_oe), 32'h1F);
                prev = 8'(b);
            end
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #1_500_000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule